// File: doc/BRIEF.md
# Clock source selector and postscaler

This block produces the system clock of a chip from one of two references: an internal oscillator, which is the choice out of reset, and an external reference, which may be a crystal oscillator output or a clock signal driven straight in from a pin. All three clocks it uses arrive as digital inputs: internal reference, external reference, and a free-running monitor clock.

The external reference is taken into use only when software asks for it and the oscillator logic reports it as stable. The changeover is break-before-make. The old reference is gated off on its falling edge. The new one is gated on only after a two-flop synchronizer in its own domain has seen the request.

A monitor on the monitor clock watches the external reference while it is in use. If no edge arrives within a fixed window, the monitor raises a sticky loss flag and forces the selection back to the internal reference. The selected reference then goes through a power-of-two postscaler. A fixed halving stage follows it, so the system clock always has a 50% duty cycle.

Top module: `clk_src_ctrl`

## Requirements
- R1: While `rst_ni` is low, `sys_clk_o`, `ext_active_o` and `loss_o` are 0. After reset the system clock is derived from `int_clk_i`.
- R2: For postscale codes 0 to 8, each high phase and each low phase of `sys_clk_o` lasts exactly 2^code rising edges of the selected reference. The total division is therefore 2^(code+1) at 50% duty.
- R3: Postscale codes 9 to 15 behave exactly like code 8: each phase lasts 256 reference edges.
- R4: The external reference is selected (`ext_active_o` = 1) only while `sel_ext_i` = 1, `ext_stable_i` = 1 and `loss_o` = 0. Otherwise the internal reference is used.
- R5: Changeover is break-before-make: the internal and the external gate enables are never both on.
- R6: While the external source is requested, reported stable and not flagged lost, `loss_o` sets after 64 monitor-clock cycles with no edge seen on `ext_clk_i`. It does not set while the external reference keeps toggling.
- R7: Once `loss_o` is 1, `ext_active_o` is 0, and `sys_clk_o` keeps running from the internal reference.
- R8: `loss_o` stays set until a cycle with `loss_clr_i` = 1 (write one to clear) or reset. It never sets while `sel_ext_i` or `ext_stable_i` is 0.
- R9: A new postscale code takes effect only at a terminal count. Every phase of `sys_clk_o` therefore has either the full old length or the full new length.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| int_clk_i | input | 1 | Internal oscillator reference |
| ext_clk_i | input | 1 | External reference (crystal output or driven clock) |
| mon_clk_i | input | 1 | Free-running monitor clock; control inputs are synchronous to it |
| rst_ni | input | 1 | Active-low asynchronous reset |
| sel_ext_i | input | 1 | Source request: 1 asks for the external reference |
| ext_stable_i | input | 1 | External reference enabled and stable |
| post_code_i | input | CODE_W (4) | Postscale code; phase length 2^min(code,8) |
| loss_clr_i | input | 1 | Write-one-to-clear pulse for the loss flag |
| sys_clk_o | output | 1 | System clock, 50% duty |
| ext_active_o | output | 1 | External reference currently gated through |
| loss_o | output | 1 | Sticky reference-loss flag |

## Verification
Some properties are checked on every monitor-clock cycle by the assertions:
- the two gate enables never overlap;
- a set loss flag has already removed the external reference;
- the loss flag stays set until cleared;
- the flag only rises when the external source was being monitored.

Other behaviour can only be shown by the bench's scenarios, because it depends on edges of the reference clocks themselves:
- the exact phase lengths for each postscale code and the clamping of large codes;
- phase integrity across code changes;
- the hold-off until the stable flag is given;
- the 64-cycle loss window and the recovery after a clear.

// File: rtl/clk_src_pkg.sv
`timescale 1ns/1ps
package clk_src_pkg;

  // Codes above the largest supported exponent saturate to it.
  function automatic int unsigned clamp_code(input int unsigned code, input int unsigned max_code);
    return (code > max_code) ? max_code : code;
  endfunction

endpackage

// File: rtl/clk_src_guard.sv
`timescale 1ns/1ps
module clk_src_guard #(
  parameter int LOSS_LIMIT = 64
) (
  input  logic mon_clk_i,
  input  logic rst_ni,
  input  logic sel_ext_i,
  input  logic ext_stable_i,
  input  logic ext_clk_i,
  input  logic loss_clr_i,
  output logic use_ext_o,
  output logic loss_o
);
  localparam int CW = $clog2(LOSS_LIMIT + 1);

  logic [2:0]    ext_sync_q;
  logic [CW-1:0] idle_q;
  logic          loss_q, use_q;
  logic          edge_seen, armed, expire;

  assign edge_seen = ext_sync_q[2] ^ ext_sync_q[1];
  assign armed     = sel_ext_i & ext_stable_i & ~loss_q;
  assign expire    = armed & ~edge_seen & (idle_q == CW'(LOSS_LIMIT - 1));

  always_ff @(posedge mon_clk_i or negedge rst_ni) begin
    if (!rst_ni) ext_sync_q <= '0;
    else         ext_sync_q <= {ext_sync_q[1:0], ext_clk_i};
  end

  always_ff @(posedge mon_clk_i or negedge rst_ni) begin
    if (!rst_ni)                                  idle_q <= '0;
    else if (!armed || edge_seen || loss_clr_i || expire) idle_q <= '0;
    else                                          idle_q <= idle_q + 1'b1;
  end

  // Clear wins over a same-cycle expiry.
  always_ff @(posedge mon_clk_i or negedge rst_ni) begin
    if (!rst_ni)         loss_q <= 1'b0;
    else if (loss_clr_i) loss_q <= 1'b0;
    else if (expire)     loss_q <= 1'b1;
  end

  always_ff @(posedge mon_clk_i or negedge rst_ni) begin
    if (!rst_ni) use_q <= 1'b0;
    else         use_q <= armed & ~expire;
  end

  assign use_ext_o = use_q;
  assign loss_o    = loss_q;
endmodule

// File: rtl/clk_gate_branch.sv
`timescale 1ns/1ps
module clk_gate_branch (
  input  logic clk_i,
  input  logic arst_ni,
  input  logic want_i,
  input  logic other_en_i,
  output logic en_o
);
  logic s1_q, s2_q;

  always_ff @(posedge clk_i or negedge arst_ni) begin
    if (!arst_ni) begin
      s1_q <= 1'b0;
      s2_q <= 1'b0;
    end else begin
      s1_q <= want_i & ~other_en_i;
      s2_q <= s1_q;
    end
  end

  // Enable changes only while this clock is low.
  always_ff @(negedge clk_i or negedge arst_ni) begin
    if (!arst_ni) en_o <= 1'b0;
    else          en_o <= s2_q;
  end
endmodule

// File: rtl/clk_glitchfree_mux.sv
`timescale 1ns/1ps
module clk_glitchfree_mux (
  input  logic       int_clk_i,
  input  logic       ext_clk_i,
  input  logic       rst_ni,
  input  logic       use_ext_i,
  input  logic       kill_ext_i,
  output logic [1:0] en_o,
  output logic       ref_clk_o
);
  logic [1:0] src_clk, want, arst_n, en;

  assign src_clk = {ext_clk_i, int_clk_i};
  assign want    = {use_ext_i, ~use_ext_i};
  // A lost external clock cannot clock its own enable off: clear it asynchronously.
  assign arst_n  = {rst_ni & ~kill_ext_i, rst_ni};

  for (genvar g = 0; g < 2; g++) begin : g_branch
    clk_gate_branch u_branch (
      .clk_i      (src_clk[g]),
      .arst_ni    (arst_n[g]),
      .want_i     (want[g]),
      .other_en_i (en[1-g]),
      .en_o       (en[g])
    );
  end

  assign en_o      = en;
  assign ref_clk_o = |(src_clk & en);
endmodule

// File: rtl/clk_pow2_postdiv.sv
`timescale 1ns/1ps
module clk_pow2_postdiv
  import clk_src_pkg::*;
#(
  parameter int CODE_W   = 4,
  parameter int MAX_CODE = 8
) (
  input  logic              ref_clk_i,
  input  logic              rst_ni,
  input  logic [CODE_W-1:0] code_i,
  output logic              sys_clk_o
);
  localparam int CNT_W = (MAX_CODE < 1) ? 1 : MAX_CODE;

  logic [CODE_W-1:0] code_s1_q, code_s2_q, act_code_q;
  logic [CNT_W-1:0]  cnt_q, limit;
  logic              tc, sys_q;

  assign limit = CNT_W'((33'd1 << act_code_q) - 33'd1);
  assign tc    = (cnt_q == limit);

  always_ff @(posedge ref_clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      code_s1_q <= '0;
      code_s2_q <= '0;
    end else begin
      code_s1_q <= code_i;
      code_s2_q <= code_s1_q;
    end
  end

  // Code loads only at terminal count so no phase is cut short.
  always_ff @(posedge ref_clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q      <= '0;
      sys_q      <= 1'b0;
      act_code_q <= '0;
    end else if (tc) begin
      cnt_q      <= '0;
      sys_q      <= ~sys_q;
      act_code_q <= CODE_W'(clamp_code(32'(code_s2_q), 32'(MAX_CODE)));
    end else begin
      cnt_q      <= cnt_q + 1'b1;
    end
  end

  assign sys_clk_o = sys_q;
endmodule

// File: rtl/clk_src_ctrl.sv
`timescale 1ns/1ps
module clk_src_ctrl #(
  parameter int CODE_W     = 4,
  parameter int MAX_CODE   = 8,
  parameter int LOSS_LIMIT = 64
) (
  input  logic              int_clk_i,
  input  logic              ext_clk_i,
  input  logic              mon_clk_i,
  input  logic              rst_ni,
  input  logic              sel_ext_i,
  input  logic              ext_stable_i,
  input  logic [CODE_W-1:0] post_code_i,
  input  logic              loss_clr_i,
  output logic              sys_clk_o,
  output logic              ext_active_o,
  output logic              loss_o
);
  logic       use_ext, loss, ref_clk, int_en;
  logic [1:0] gate_en;

  clk_src_guard #(.LOSS_LIMIT(LOSS_LIMIT)) u_guard (
    .mon_clk_i    (mon_clk_i),
    .rst_ni       (rst_ni),
    .sel_ext_i    (sel_ext_i),
    .ext_stable_i (ext_stable_i),
    .ext_clk_i    (ext_clk_i),
    .loss_clr_i   (loss_clr_i),
    .use_ext_o    (use_ext),
    .loss_o       (loss)
  );

  clk_glitchfree_mux u_mux (
    .int_clk_i  (int_clk_i),
    .ext_clk_i  (ext_clk_i),
    .rst_ni     (rst_ni),
    .use_ext_i  (use_ext),
    .kill_ext_i (loss),
    .en_o       (gate_en),
    .ref_clk_o  (ref_clk)
  );

  clk_pow2_postdiv #(.CODE_W(CODE_W), .MAX_CODE(MAX_CODE)) u_div (
    .ref_clk_i (ref_clk),
    .rst_ni    (rst_ni),
    .code_i    (post_code_i),
    .sys_clk_o (sys_clk_o)
  );

  assign int_en       = gate_en[0];
  assign ext_active_o = gate_en[1];
  assign loss_o       = loss;
endmodule

// File: rtl/clk_src_ctrl_chk.sv
`timescale 1ns/1ps
module clk_src_ctrl_chk (
  input logic mon_clk_i,
  input logic rst_ni,
  input logic sel_ext_i,
  input logic ext_stable_i,
  input logic loss_clr_i,
  input logic loss_i,
  input logic int_en_i,
  input logic ext_active_i
);
  // R5
  a_r5_break_before_make: assert property (@(posedge mon_clk_i) disable iff (!rst_ni)
    !(int_en_i && ext_active_i));

  // R7
  a_r7_loss_drops_ext: assert property (@(posedge mon_clk_i) disable iff (!rst_ni)
    loss_i |-> !ext_active_i);

  // R8
  a_r8_loss_sticky: assert property (@(posedge mon_clk_i) disable iff (!rst_ni)
    (loss_i && !loss_clr_i) |=> loss_i);

  // R8
  a_r8_loss_only_when_monitored: assert property (@(posedge mon_clk_i) disable iff (!rst_ni)
    $rose(loss_i) |-> $past(sel_ext_i && ext_stable_i));
endmodule

bind clk_src_ctrl clk_src_ctrl_chk u_chk (
  .mon_clk_i    (mon_clk_i),
  .rst_ni       (rst_ni),
  .sel_ext_i    (sel_ext_i),
  .ext_stable_i (ext_stable_i),
  .loss_clr_i   (loss_clr_i),
  .loss_i       (loss_o),
  .int_en_i     (int_en),
  .ext_active_i (ext_active_o)
);

// File: tb/clk_src_ctrl_bench.sv
`timescale 1ns/1ps
module clk_src_ctrl_bench;
  logic       clk = 1'b0, int_clk = 1'b0, ext_clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic       sel_ext = 1'b0, ext_stable = 1'b0, loss_clr = 1'b0;
  logic [3:0] post_code = 4'd0;
  logic       sys_clk, ext_active, loss;
  bit         ext_run = 1'b1;

  int checks = 0, fails = 0;

  // model state: expected phase length per selected source
  bit    meas_on = 1'b0, meas_ext = 1'b0;
  int    cnt = 0, skip = 0, exp_half = 1, alt_half = 1, loose = 0;
  string cur_req = "R2";

  always #2.5 clk = ~clk;
  always #7   int_clk = ~int_clk;
  initial forever begin
    #13;
    if (ext_run) ext_clk = ~ext_clk;
    else         ext_clk = 1'b0;
  end

  clk_src_ctrl u_clk_src_ctrl (
    .int_clk_i    (int_clk),
    .ext_clk_i    (ext_clk),
    .mon_clk_i    (clk),
    .rst_ni       (rst_ni),
    .sel_ext_i    (sel_ext),
    .ext_stable_i (ext_stable),
    .post_code_i  (post_code),
    .loss_clr_i   (loss_clr),
    .sys_clk_o    (sys_clk),
    .ext_active_o (ext_active),
    .loss_o       (loss)
  );

  always @(posedge int_clk) if (meas_on && !meas_ext) cnt++;
  always @(posedge ext_clk) if (meas_on && meas_ext) cnt++;

  always @(sys_clk) begin
    if (rst_ni && meas_on) begin
      if (skip > 0) skip--;
      else begin
        checks++;
        if (!(cnt == exp_half || (loose > 0 && cnt == alt_half))) begin
          fails++;
          $display("FAIL %s phase length: actual=%0d expected=%0d (alt %0d)",
                   cur_req, cnt, exp_half, (loose > 0) ? alt_half : exp_half);
        end
        if (loose > 0) loose--;
      end
    end
    cnt = 0;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wait_mon(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wait_halves(input int n);
    repeat (n) @(sys_clk);
    @(negedge clk);
  endtask

  task automatic set_meas(input bit ext, input int half, input string req);
    meas_on  = 1'b0;
    meas_ext = ext;
    exp_half = half;
    alt_half = half;
    loose    = 0;
    cur_req  = req;
    cnt      = 0;
    skip     = 2;
    meas_on  = 1'b1;
  endtask

  task automatic change_code(input logic [3:0] code, input int half, input string req);
    post_code = code;
    alt_half  = exp_half;
    exp_half  = half;
    loose     = 4;
    cur_req   = req;
  endtask

  task automatic finish_run;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    wait_mon(6);
    // R1 reset state
    chk(sys_clk == 1'b0, "R1 sys_clk in reset", sys_clk, 0);
    chk(ext_active == 1'b0, "R1 ext_active in reset", ext_active, 0);
    chk(loss == 1'b0, "R1 loss in reset", loss, 0);
    rst_ni = 1'b1;

    // R1 internal after reset, R2 code 0
    set_meas(1'b0, 1, "R1_R2 code0 int");
    wait_halves(8);
    change_code(4'd3, 8, "R9 code0->3");
    wait_halves(10);
    change_code(4'd8, 256, "R9 code3->8");
    wait_halves(6);
    // R3 saturating codes
    change_code(4'd15, 256, "R3 code15");
    wait_halves(4);
    change_code(4'd11, 256, "R3 code11");
    wait_halves(4);
    change_code(4'd2, 4, "R9 code11->2");
    wait_halves(10);

    // R4 request without stable flag
    sel_ext = 1'b1;
    wait_mon(200);
    chk(ext_active == 1'b0, "R4 held off until stable", ext_active, 0);
    chk(loss == 1'b0, "R8 no loss while not stable", loss, 0);
    wait_halves(4);

    // R4 stable given: switch over
    meas_on = 1'b0;
    ext_stable = 1'b1;
    wait_mon(100);
    chk(ext_active == 1'b1, "R4 ext selected", ext_active, 1);
    set_meas(1'b1, 4, "R2 ext code2");
    wait_halves(8);
    change_code(4'd1, 2, "R9 ext code2->1");
    wait_halves(8);
    chk(loss == 1'b0, "R6 no loss while toggling", loss, 0);

    // R6 reference loss
    meas_on = 1'b0;
    ext_run = 1'b0;
    wait_mon(40);
    chk(loss == 1'b0, "R6 no loss before window", loss, 0);
    wait_mon(50);
    chk(loss == 1'b1, "R6 loss after window", loss, 1);
    chk(ext_active == 1'b0, "R7 ext dropped on loss", ext_active, 0);
    set_meas(1'b0, 2, "R7 internal after loss");
    wait_halves(6);

    // R8 sticky with ext running again
    ext_run = 1'b1;
    wait_mon(100);
    chk(loss == 1'b1, "R8 loss sticky", loss, 1);
    chk(ext_active == 1'b0, "R7 ext stays off", ext_active, 0);

    // R8 write-one-to-clear
    meas_on = 1'b0;
    loss_clr = 1'b1;
    wait_mon(1);
    loss_clr = 1'b0;
    wait_mon(2);
    chk(loss == 1'b0, "R8 loss cleared", loss, 0);
    wait_mon(100);
    chk(ext_active == 1'b1, "R4 ext back after clear", ext_active, 1);
    set_meas(1'b1, 2, "R2 ext after clear");
    wait_halves(6);

    // R4 deselect returns to internal
    meas_on = 1'b0;
    sel_ext = 1'b0;
    wait_mon(100);
    chk(ext_active == 1'b0, "R4 deselected", ext_active, 0);
    set_meas(1'b0, 2, "R2 int after deselect");
    wait_halves(6);

    // R8 no loss when not monitored
    ext_run = 1'b0;
    wait_mon(150);
    chk(loss == 1'b0, "R8 unmonitored ext stop", loss, 0);
    wait_halves(4);

    finish_run();
  end
endmodule